// File: doc/BRIEF.md
# Per-Port Packet Mailbox Controller

This block sits between a host's 32-bit memory-mapped bus and a device-side packet engine that serves up to four line ports. The host sees two windows. One is a 128-byte configuration window holding a doorbell flags word, an interrupt enable, an interrupt clear and a read-only version word. The other is a 32 KiB buffer window. The block does not store buffer contents. It decodes each buffer access into a port, a direction and a byte offset for an external packet RAM.

Each port has one transmit buffer and one receive buffer of 4 KiB each. The host writes a packet into the port's transmit buffer and then rings the doorbell by setting the port's transmit-busy bit. The device engine drains the buffer and pulses its consumed strobe, which frees the buffer again. When the engine deposits a received packet, it pulses its deposit strobe, which raises the port's receive-ready bit. The host reads the packet and then acknowledges it. Either kind of completion latches a pending event. That event drives a level-high interrupt while the interrupt is enabled.

By software convention, each packet begins with an 8-byte header of four little-endian 16-bit fields: payload length (header excluded), path id, channel id and kind (0 data, 1 command, 3 channel open, 4 channel close). The payload is at most 4088 bytes, so header and payload fit in one buffer.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, all transmit-busy and receive-ready bits are 0, the interrupt enable reads 0, no event is pending and `irq` is 0.
- R2: A host write to configuration offset 0x7C sets transmit-busy bit p (flags bit p, p = 0..3) wherever the written bit p is 1, and leaves it unchanged where it is 0. A `dev_tx_done[p]` pulse clears the bit.
- R3: A `dev_rx_put[p]` pulse sets receive-ready bit p (flags bit 4+p). A host write to 0x7C with bit 4+p set to 1 clears it, and a 0 in that bit leaves it unchanged.
- R4: When a host write to the flags word and a device strobe act on the same bit in the same cycle, the device strobe wins: busy ends 0 and ready ends 1.
- R5: Flags bits [31:8] read as 0. Offset 0x70 and any configuration offset other than 0x74, 0x78 and 0x7C read as 0.
- R6: Offset 0x74 reads {major[31:24], minor[23:16], build[15:0]} from parameters, and writes to it have no effect.
- R7: Offset 0x78 bit 0 is the interrupt enable and reads back in bit 0. `irq` is 1 exactly when the enable is 1 and an event is pending, one cycle after the edge that changed either.
- R8: An event is latched when any receive-ready bit goes 0 to 1 or any transmit-busy bit goes 1 to 0. Any write to 0x70 clears the latch, unless a new event occurs in the same cycle, in which case the latch stays set.
- R9: The host setting a busy bit or acknowledging a ready bit raises no event.
- R10: A buffer-window access with address a (byte address, 15 bits) gives port a[14:13], transmit side when a[12] is 1 and receive side when it is 0, and offset a[11:0]. `buf_hit` is 1 only while `host_buf_sel` is 1 and the port index is below the port count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cfg_sel | input | 1 | Host access targets the configuration window |
| host_buf_sel | input | 1 | Host access targets the buffer window |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 15 | Byte address within the selected window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Configuration read data (combinational) |
| buf_hit | output | 1 | Buffer access decodes to a present port |
| buf_port | output | 2 | Decoded port index |
| buf_is_tx | output | 1 | 1 for the transmit buffer, 0 for the receive buffer |
| buf_off | output | 12 | Byte offset within the 4 KiB buffer |
| dev_tx_done | input | NPORTS | Device consumed the port's transmit buffer |
| dev_rx_put | input | NPORTS | Device deposited a packet in the port's receive buffer |
| tx_busy | output | NPORTS | Transmit-busy bits |
| rx_ready | output | NPORTS | Receive-ready bits |
| irq | output | 1 | Level-high interrupt request |

## Verification
On every cycle the assertions check four things: device strobes beat host writes, the flag bits hold whenever neither side touches them, a completion always leaves an event pending, and disabling the interrupt drops `irq` on the next cycle. They also check that the unused upper flag bits read as zero and that the buffer decode never reports a hit without a select. The bench sweeps all sixteen port masks for doorbell and acknowledge traffic, and it sweeps the buffer decode over every port and side. Only these scenarios show certain things: that acknowledges and doorbells leave no event behind, that a clear arriving with a new event keeps the interrupt up, and that the version word cannot be written.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Buffer geometry: 4 KiB per buffer, receive then transmit, four port slots.
  localparam int BUF_AW = 12;
  localparam int WIN_AW = BUF_AW + 3;
  localparam int MAX_PORTS = 4;

  // Configuration word offsets (bytes).
  localparam logic [6:0] OFF_FLAGS = 7'h7C;
  localparam logic [6:0] OFF_IEN   = 7'h78;
  localparam logic [6:0] OFF_VER   = 7'h74;
  localparam logic [6:0] OFF_ICLR  = 7'h70;

  // Flag word field positions: transmit-busy low nibble, receive-ready next.
  localparam int TX_LO = 0;
  localparam int RX_LO = 4;

  // Packet header convention shared with software.
  localparam int HDR_BYTES   = 8;
  localparam int MAX_PAYLOAD = (1 << BUF_AW) - HDR_BYTES;

  typedef struct packed {
    logic [1:0]        port;
    logic              is_tx;
    logic [BUF_AW-1:0] off;
  } buf_loc_t;

  function automatic buf_loc_t buf_locate(input logic [WIN_AW-1:0] a);
    buf_loc_t r;
    r.port  = a[WIN_AW-1 -: 2];
    r.is_tx = a[BUF_AW];
    r.off   = a[BUF_AW-1:0];
    return r;
  endfunction

  function automatic logic [31:0] ver_word(input logic [7:0] maj,
                                           input logic [7:0] min,
                                           input logic [15:0] build);
    return {maj, min, build};
  endfunction
endpackage

// File: rtl/mbox_flag_cell.sv
module mbox_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic host_set,
  input  logic host_ack,
  input  logic dev_done,
  input  logic dev_put,
  output logic busy,
  output logic ready,
  output logic ev
);
  logic busy_nx, ready_nx;

  // Device strobes take priority over host writes.
  always_comb begin
    busy_nx  = dev_done ? 1'b0 : (host_set ? 1'b1 : busy);
    ready_nx = dev_put  ? 1'b1 : (host_ack ? 1'b0 : ready);
  end

  assign ev = (busy & ~busy_nx) | (~ready & ready_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ready <= 1'b0;
    end else begin
      busy  <= busy_nx;
      ready <= ready_nx;
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_val,
  input  logic clr_wr,
  input  logic ev_any,
  output logic irq_en,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (en_wr) irq_en <= en_val;
      pend <= ev_any | (pend & ~clr_wr);
    end
  end

  assign irq = irq_en & pend;
endmodule

// File: rtl/mbox_bufdec.sv
module mbox_bufdec
  import mbox_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic              sel,
  input  logic [WIN_AW-1:0] addr,
  output logic              hit,
  output logic [1:0]        port,
  output logic              is_tx,
  output logic [BUF_AW-1:0] off
);
  buf_loc_t loc;

  always_comb begin
    loc   = buf_locate(addr);
    port  = loc.port;
    is_tx = loc.is_tx;
    off   = loc.off;
    hit   = sel && (int'(loc.port) < NPORTS);
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int          NPORTS    = 4,
  parameter logic [7:0]  VER_MAJOR = 8'h02,
  parameter logic [7:0]  VER_MINOR = 8'h05,
  parameter logic [15:0] VER_BUILD = 16'h1A2B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cfg_sel,
  input  logic              host_buf_sel,
  input  logic              host_wr,
  input  logic [14:0]       host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              buf_hit,
  output logic [1:0]        buf_port,
  output logic              buf_is_tx,
  output logic [11:0]       buf_off,
  input  logic [NPORTS-1:0] dev_tx_done,
  input  logic [NPORTS-1:0] dev_rx_put,
  output logic [NPORTS-1:0] tx_busy,
  output logic [NPORTS-1:0] rx_ready,
  output logic              irq
);
  localparam int CFG_AW = 7;

  logic [CFG_AW-1:0] cfg_off;
  logic              cfg_wr, cfg_flag_wr, cfg_ien_wr, cfg_clr_wr;
  logic [NPORTS-1:0] cell_ev;
  logic              ev_any, irq_en, irq_pend;
  logic [31:0]       flag_word;

  assign cfg_off     = host_addr[CFG_AW-1:0];
  assign cfg_wr      = host_cfg_sel & host_wr;
  assign cfg_flag_wr = cfg_wr & (cfg_off == OFF_FLAGS);
  assign cfg_ien_wr  = cfg_wr & (cfg_off == OFF_IEN);
  assign cfg_clr_wr  = cfg_wr & (cfg_off == OFF_ICLR);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    mbox_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_set (cfg_flag_wr & host_wdata[TX_LO+p]),
      .host_ack (cfg_flag_wr & host_wdata[RX_LO+p]),
      .dev_done (dev_tx_done[p]),
      .dev_put  (dev_rx_put[p]),
      .busy     (tx_busy[p]),
      .ready    (rx_ready[p]),
      .ev       (cell_ev[p])
    );
  end

  assign ev_any = |cell_ev;

  mbox_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (cfg_ien_wr),
    .en_val (host_wdata[0]),
    .clr_wr (cfg_clr_wr),
    .ev_any (ev_any),
    .irq_en (irq_en),
    .pend   (irq_pend),
    .irq    (irq)
  );

  mbox_bufdec #(.NPORTS(NPORTS)) u_bufdec (
    .sel   (host_buf_sel),
    .addr  (host_addr),
    .hit   (buf_hit),
    .port  (buf_port),
    .is_tx (buf_is_tx),
    .off   (buf_off)
  );

  always_comb begin
    flag_word = '0;
    for (int p = 0; p < NPORTS; p++) begin
      flag_word[TX_LO+p] = tx_busy[p];
      flag_word[RX_LO+p] = rx_ready[p];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_cfg_sel) begin
      unique case (cfg_off)
        OFF_FLAGS: host_rdata = flag_word;
        OFF_IEN:   host_rdata = {31'b0, irq_en};
        OFF_VER:   host_rdata = ver_word(VER_MAJOR, VER_MINOR, VER_BUILD);
        default:   host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cfg_sel,
  input logic              host_buf_sel,
  input logic              host_wr,
  input logic [14:0]       host_addr,
  input logic [31:0]       host_wdata,
  input logic [31:0]       host_rdata,
  input logic              buf_hit,
  input logic [NPORTS-1:0] dev_tx_done,
  input logic [NPORTS-1:0] dev_rx_put,
  input logic [NPORTS-1:0] tx_busy,
  input logic [NPORTS-1:0] rx_ready,
  input logic              irq,
  input logic              ev_any,
  input logic              irq_pend
);
  logic flag_wr_c, ien_off_wr_c, flag_rd_c;
  assign flag_wr_c    = host_cfg_sel && host_wr && (host_addr[6:0] == 7'h7C);
  assign ien_off_wr_c = host_cfg_sel && host_wr && (host_addr[6:0] == 7'h78) && !host_wdata[0];
  assign flag_rd_c    = host_cfg_sel && !host_wr && (host_addr[6:0] == 7'h7C);

  p_done_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_done != '0) |=> ((tx_busy & $past(dev_tx_done)) == '0));

  p_put_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rx_put != '0) |=> ((rx_ready & $past(dev_rx_put)) == $past(dev_rx_put)));

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_c && dev_tx_done == '0 && dev_rx_put == '0) |=> ($stable(tx_busy) && $stable(rx_ready)));

  p_event_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> irq_pend);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ien_off_wr_c |=> !irq);

  p_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_c |-> (host_rdata[31:8] == 24'b0));

  p_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_buf_sel |-> !buf_hit);
endmodule

bind mbox_ctrl mbox_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_cfg_sel (host_cfg_sel),
  .host_buf_sel (host_buf_sel),
  .host_wr      (host_wr),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .host_rdata   (host_rdata),
  .buf_hit      (buf_hit),
  .dev_tx_done  (dev_tx_done),
  .dev_rx_put   (dev_rx_put),
  .tx_busy      (tx_busy),
  .rx_ready     (rx_ready),
  .irq          (irq),
  .ev_any       (ev_any),
  .irq_pend     (irq_pend)
);

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb;
  localparam logic [31:0] EXP_VER = 32'h02051A2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cfg_sel = 1'b0, host_buf_sel = 1'b0, host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        buf_hit, buf_is_tx;
  logic [1:0]  buf_port;
  logic [11:0] buf_off;
  logic [3:0]  dev_tx_done = '0, dev_rx_put = '0;
  logic [3:0]  tx_busy, rx_ready;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_cfg_sel(host_cfg_sel), .host_buf_sel(host_buf_sel),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .buf_hit(buf_hit), .buf_port(buf_port), .buf_is_tx(buf_is_tx), .buf_off(buf_off),
    .dev_tx_done(dev_tx_done), .dev_rx_put(dev_rx_put), .tx_busy(tx_busy),
    .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with optional config write and device strobes; entered and left at negedge.
  task automatic step(input logic wr, input logic [6:0] off, input logic [31:0] d,
                      input logic [3:0] done, input logic [3:0] put);
    host_cfg_sel = wr; host_wr = wr; host_addr = {8'b0, off}; host_wdata = d;
    dev_tx_done = done; dev_rx_put = put;
    @(posedge clk); @(negedge clk);
    host_cfg_sel = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    dev_tx_done = '0; dev_rx_put = '0;
  endtask

  task automatic rd(input logic [6:0] off, output logic [31:0] v);
    host_cfg_sel = 1; host_wr = 0; host_addr = {8'b0, off};
    #1 v = host_rdata;
    host_cfg_sel = 0; host_addr = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(7'h7C, v); chk("R1 flags", v, 32'h0);
    rd(7'h78, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R6 version, write ignored
    rd(7'h74, v); chk("R6 version", v, EXP_VER);
    step(1, 7'h74, 32'hFFFF_FFFF, 0, 0);
    rd(7'h74, v); chk("R6 version after write", v, EXP_VER);
    rd(7'h7C, v); chk("R6 write left flags", v, 32'h0);

    // R7 enable read back
    step(1, 7'h78, 32'hFFFF_FFFF, 0, 0);
    rd(7'h78, v); chk("R7 enable readback", v, 32'h1);

    // R2/R8/R9 transmit sweep over all masks
    for (int m = 0; m < 16; m++) begin
      step(1, 7'h7C, m, 0, 0);
      rd(7'h7C, v); chk("R2 busy set", v, m);
      chk("R9 no event on doorbell", {31'b0, irq}, 32'h0);
      step(1, 7'h7C, 0, 0, 0);
      rd(7'h7C, v); chk("R2 zero write holds", v, m);
      step(0, 0, 0, 4'(m), 0);
      rd(7'h7C, v); chk("R2 done clears", v, 32'h0);
      chk("R8 tx event", {31'b0, irq}, (m != 0) ? 32'h1 : 32'h0);
      step(1, 7'h70, 0, 0, 0);
      chk("R8 clear", {31'b0, irq}, 32'h0);
    end

    // R3/R8/R9 receive sweep
    for (int m = 0; m < 16; m++) begin
      step(0, 0, 0, 0, 4'(m));
      rd(7'h7C, v); chk("R3 ready set", v, m << 4);
      chk("R8 rx event", {31'b0, irq}, (m != 0) ? 32'h1 : 32'h0);
      step(1, 7'h70, 0, 0, 0);
      step(1, 7'h7C, 0, 0, 0);
      rd(7'h7C, v); chk("R3 zero write holds", v, m << 4);
      step(1, 7'h7C, m << 4, 0, 0);
      rd(7'h7C, v); chk("R3 ack clears", v, 32'h0);
      chk("R9 no event on ack", {31'b0, irq}, 32'h0);
    end

    // R4 collisions
    step(1, 7'h7C, 32'h1, 4'h1, 0);
    rd(7'h7C, v); chk("R4 done beats set", v, 32'h0);
    step(0, 0, 0, 0, 4'h2);
    step(1, 7'h70, 0, 0, 0);
    step(1, 7'h7C, 32'h20, 0, 4'h2);
    rd(7'h7C, v); chk("R4 put beats ack", v, 32'h20);
    step(1, 7'h7C, 32'h20, 0, 0);

    // R5 upper bits and unmapped offsets
    step(1, 7'h7C, 32'hFFFF_FF0F, 0, 0);
    rd(7'h7C, v); chk("R5 upper zero", v, 32'h0F);
    rd(7'h70, v); chk("R5 clear reads zero", v, 32'h0);
    rd(7'h40, v); chk("R5 unmapped zero", v, 32'h0);
    step(0, 0, 0, 4'hF, 0);
    step(1, 7'h70, 0, 0, 0);

    // R7 gating, R8 clear racing an event
    step(0, 0, 0, 0, 4'h8);
    chk("R7 pending irq", {31'b0, irq}, 32'h1);
    step(1, 7'h78, 32'h0, 0, 0);
    chk("R7 disabled irq", {31'b0, irq}, 32'h0);
    step(1, 7'h78, 32'h1, 0, 0);
    chk("R7 re-enabled irq", {31'b0, irq}, 32'h1);
    step(1, 7'h70, 0, 0, 4'h4);
    chk("R8 event beats clear", {31'b0, irq}, 32'h1);
    step(1, 7'h70, 0, 0, 0);
    chk("R8 clear after race", {31'b0, irq}, 32'h0);

    // R10 buffer decode sweep
    host_buf_sel = 1;
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 3; k++) begin
          int o;
          o = (k == 0) ? 0 : (k == 1) ? 4092 : (p * 256 + 4);
          host_addr = 15'(p * 8192 + t * 4096 + o);
          #1;
          chk("R10 decode", {17'b0, buf_hit, buf_port, buf_is_tx, buf_off},
              {17'b0, 1'b1, 2'(p), 1'(t), 12'(o)});
        end
    host_buf_sel = 0; #1;
    chk("R10 no select", {31'b0, buf_hit}, 32'h0);
    host_addr = '0;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule